// File: doc/BRIEF.md
# Integer ALU with status flags

This block is the integer execution datapath of a 32-bit core. Each cycle it takes an operation code, two operands and the current carry, compare-flag and overflow-enable bits. It returns a combinational result for the same cycle. The operations cover addition with or without carry-in, subtraction, bitwise logic, three shifts and a rotate, signed and unsigned compares, byte and halfword extension, a flag-driven select, and lowest-set-bit and highest-set-bit search.

The block owns a small status register holding carry, overflow and compare flag. Only operations that define a flag write that flag, and only in a cycle where the valid strobe is high. Every other flag keeps its value. A range-exception output is raised for one cycle after an addition that overflows while overflow trapping is enabled. The surrounding core routes `cy_o` and `f_o` back to `cy_i` and `f_i`, and it owns decode, the register file and exception entry.

Top module: `int_alu`

## Requirements
- R1: ADD returns a+b modulo 2^32. OV becomes 1 exactly when a and b share a sign bit and the result's sign bit differs from it.
- R2: ADD sets CY to 1 exactly when the unsigned result is below operand b, and clears it otherwise.
- R3: ADDC returns a+b+cy_i modulo 2^32 and uses the R1 overflow rule. With cy_i=1, CY is set when the unsigned result is at most b. With cy_i=0, CY is set when the result is strictly below b. So 0+0xFFFFFFFF+1 gives result 0 and CY=1.
- R4: `range_exc_o` is high in the cycle after a valid ADD or ADDC whose new OV is 1 while `ove_i` is 1. It is low after every other cycle.
- R5: SUB returns a-b modulo 2^32. AND, OR and XOR return the bitwise result. None of these four changes CY, OV or F.
- R6: SLL, SRL and SRA (arithmetic) shift a by b[4:0]. ROR rotates a right by b[4:0], so an amount whose low five bits are zero returns a unchanged. Shifts leave all flags unchanged.
- R7: The ten compares (EQ, NE, and GT, GE, LT, LE in signed and unsigned forms) compare a with b and write F with the outcome. They leave CY and OV unchanged and return result 0.
- R8: CMOV returns a when f_i is 1 and b when f_i is 0, with flags unchanged.
- R9: FF1 returns the 1-based position of the lowest set bit of a. FL1 returns the 1-based position of the highest set bit of a. Both return 0 for a=0.
- R10: EXTBS and EXTBZ sign- or zero-extend a[7:0]. EXTHS and EXTHZ do the same for a[15:0]. Flags stay unchanged.
- R11: After reset CY, OV, F and `range_exc_o` are 0. The flags change only at a clock edge where `valid_i` is 1. The result output follows the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe; flags update only when high |
| op_i | input | 5 | Operation code (values of `alu_op_e` in `alu_pkg`) |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B (shift amount for shifts and rotate) |
| cy_i | input | 1 | Current carry, used as carry-in by ADDC |
| f_i | input | 1 | Current compare flag, used by CMOV |
| ove_i | input | 1 | Overflow trap enable |
| result_o | output | 32 | Combinational result |
| cy_o | output | 1 | Registered carry flag |
| ov_o | output | 1 | Registered overflow flag |
| f_o | output | 1 | Registered compare flag |
| range_exc_o | output | 1 | One-cycle range exception pulse |

## Verification
An overflowing addition makes two things happen at the same clock edge: the OV and CY register update, and the range-exception decision is taken from the new OV and `ove_i`. The bench triggers this with signed-boundary additions such as 0x7FFFFFFF+1 and 0x80000000+0x80000000. It runs them with trapping both enabled and disabled, and with a carry-out occurring alongside the overflow. It checks the result before the edge, then reads the flags and the pulse after the edge. It also checks that the pulse has dropped one cycle later. Flags set by an addition are then carried through logic, compare and idle cycles to confirm that no other operation clears them.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
    localparam int OP_W   = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD    = 5'd0,
        OP_ADDC   = 5'd1,
        OP_SUB    = 5'd2,
        OP_AND    = 5'd3,
        OP_OR     = 5'd4,
        OP_XOR    = 5'd5,
        OP_SLL    = 5'd6,
        OP_SRL    = 5'd7,
        OP_SRA    = 5'd8,
        OP_ROR    = 5'd9,
        OP_CMPEQ  = 5'd10,
        OP_CMPNE  = 5'd11,
        OP_CMPGTS = 5'd12,
        OP_CMPGES = 5'd13,
        OP_CMPLTS = 5'd14,
        OP_CMPLES = 5'd15,
        OP_CMPGTU = 5'd16,
        OP_CMPGEU = 5'd17,
        OP_CMPLTU = 5'd18,
        OP_CMPLEU = 5'd19,
        OP_EXTBS  = 5'd20,
        OP_EXTBZ  = 5'd21,
        OP_EXTHS  = 5'd22,
        OP_EXTHZ  = 5'd23,
        OP_CMOV   = 5'd24,
        OP_FF1    = 5'd25,
        OP_FL1    = 5'd26
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_ARITH = 2'd2,
        SH_ROT   = 2'd3
    } shift_kind_e;

    typedef struct packed {
        logic cy;
        logic ov;
        logic f;
        logic exc;
    } alu_status_t;
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff  = sub_i ? ~b_i : b_i;
        wide   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
        sum_o  = wide[W-1:0];
        cout_o = wide[W];
        ovf_o  = (a_i[W-1] == b_eff[W-1]) && (wide[W-1] != a_i[W-1]);
    end

    // Carry-out must agree with the unsigned comparison rule (R2, R3)
    always_comb begin
        if (!sub_i) begin
            p_carry_rule_r3: assert (cout_o == (cin_i ? (sum_o <= b_i) : (sum_o < b_i)))
                else $error("adder carry disagrees with comparison rule");
        end
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]             a_i,
    input  logic [SHW-1:0]           amt_i,
    input  alu_pkg::shift_kind_e     kind_i,
    output logic [W-1:0]             res_o
);
    import alu_pkg::*;
    logic [2*W-1:0] doubled;

    always_comb begin
        doubled = {a_i, a_i} >> amt_i;
        unique case (kind_i)
            SH_LEFT:  res_o = a_i << amt_i;
            SH_RIGHT: res_o = a_i >> amt_i;
            SH_ARITH: res_o = W'($signed(a_i) >>> amt_i);
            default:  res_o = doubled[W-1:0];
        endcase
    end

    // Rotating by zero returns the operand (R6)
    always_comb begin
        if (kind_i == SH_ROT && amt_i == '0) begin
            p_rot_zero_r6: assert (res_o == a_i)
                else $error("rotate by zero altered operand");
        end
    end
endmodule

// File: rtl/alu_bitscan.sv
module alu_bitscan #(
    parameter int W         = 32,
    parameter bit FROM_HIGH = 1'b0,
    parameter int IW        = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [IW-1:0] idx_o
);
    generate
        if (FROM_HIGH) begin : g_last
            always_comb begin
                idx_o = '0;
                for (int i = 0; i < W; i++) begin
                    if (vec_i[i]) idx_o = IW'(i + 1);
                end
            end
        end else begin : g_first
            always_comb begin
                idx_o = '0;
                for (int i = W - 1; i >= 0; i--) begin
                    if (vec_i[i]) idx_o = IW'(i + 1);
                end
            end
        end
    endgenerate

    // A nonzero input always yields a nonzero position within range (R9)
    always_comb begin
        if (vec_i != '0) begin
            p_index_range_r9: assert (idx_o != '0 && idx_o <= IW'(W))
                else $error("bit scan index out of range");
        end
    end
endmodule

// File: rtl/int_alu.sv
module int_alu #(
    parameter int W = alu_pkg::DATA_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      valid_i,
    input  logic [alu_pkg::OP_W-1:0]  op_i,
    input  logic [W-1:0]              a_i,
    input  logic [W-1:0]              b_i,
    input  logic                      cy_i,
    input  logic                      f_i,
    input  logic                      ove_i,
    output logic [W-1:0]              result_o,
    output logic                      cy_o,
    output logic                      ov_o,
    output logic                      f_o,
    output logic                      range_exc_o
);
    import alu_pkg::*;

    localparam int SHW = $clog2(W);
    localparam int IW  = $clog2(W + 1);

    alu_op_e      op;
    alu_status_t  st_d, st_q;

    logic [W-1:0]   sum;
    logic           add_cout, add_ovf, is_sub, add_cin;
    logic [W-1:0]   sh_res;
    shift_kind_e    sh_kind;
    logic [IW-1:0]  first_idx, last_idx;
    logic           cmp_hit, is_cmp, is_add;

    assign op = alu_op_e'(op_i);

    always_comb begin
        is_sub  = (op == OP_SUB);
        add_cin = (op == OP_ADDC) ? cy_i : is_sub;
        unique case (op)
            OP_SLL:  sh_kind = SH_LEFT;
            OP_SRL:  sh_kind = SH_RIGHT;
            OP_SRA:  sh_kind = SH_ARITH;
            default: sh_kind = SH_ROT;
        endcase
    end

    alu_adder #(.W(W)) u_adder (
        .a_i(a_i), .b_i(b_i), .cin_i(add_cin), .sub_i(is_sub),
        .sum_o(sum), .cout_o(add_cout), .ovf_o(add_ovf)
    );

    alu_shift #(.W(W), .SHW(SHW)) u_shift (
        .a_i(a_i), .amt_i(b_i[SHW-1:0]), .kind_i(sh_kind), .res_o(sh_res)
    );

    alu_bitscan #(.W(W), .FROM_HIGH(1'b0), .IW(IW)) u_first (
        .vec_i(a_i), .idx_o(first_idx)
    );

    alu_bitscan #(.W(W), .FROM_HIGH(1'b1), .IW(IW)) u_last (
        .vec_i(a_i), .idx_o(last_idx)
    );

    // Compare outcome and class decode
    always_comb begin
        is_cmp = 1'b1;
        unique case (op)
            OP_CMPEQ:  cmp_hit = (a_i == b_i);
            OP_CMPNE:  cmp_hit = (a_i != b_i);
            OP_CMPGTS: cmp_hit = ($signed(a_i) >  $signed(b_i));
            OP_CMPGES: cmp_hit = ($signed(a_i) >= $signed(b_i));
            OP_CMPLTS: cmp_hit = ($signed(a_i) <  $signed(b_i));
            OP_CMPLES: cmp_hit = ($signed(a_i) <= $signed(b_i));
            OP_CMPGTU: cmp_hit = (a_i >  b_i);
            OP_CMPGEU: cmp_hit = (a_i >= b_i);
            OP_CMPLTU: cmp_hit = (a_i <  b_i);
            OP_CMPLEU: cmp_hit = (a_i <= b_i);
            default: begin
                cmp_hit = 1'b0;
                is_cmp  = 1'b0;
            end
        endcase
        is_add = (op == OP_ADD) || (op == OP_ADDC);
    end

    // Result selection
    always_comb begin
        unique case (op)
            OP_ADD, OP_ADDC, OP_SUB:        result_o = sum;
            OP_AND:                         result_o = a_i & b_i;
            OP_OR:                          result_o = a_i | b_i;
            OP_XOR:                         result_o = a_i ^ b_i;
            OP_SLL, OP_SRL, OP_SRA, OP_ROR: result_o = sh_res;
            OP_EXTBS: result_o = {{(W-BYTE_W){a_i[BYTE_W-1]}}, a_i[BYTE_W-1:0]};
            OP_EXTBZ: result_o = {{(W-BYTE_W){1'b0}}, a_i[BYTE_W-1:0]};
            OP_EXTHS: result_o = {{(W-HALF_W){a_i[HALF_W-1]}}, a_i[HALF_W-1:0]};
            OP_EXTHZ: result_o = {{(W-HALF_W){1'b0}}, a_i[HALF_W-1:0]};
            OP_CMOV:  result_o = f_i ? a_i : b_i;
            OP_FF1:   result_o = W'(first_idx);
            OP_FL1:   result_o = W'(last_idx);
            default:  result_o = '0;
        endcase
    end

    // Next status
    always_comb begin
        st_d     = st_q;
        st_d.exc = 1'b0;
        if (valid_i) begin
            if (is_add) begin
                st_d.cy  = add_cout;
                st_d.ov  = add_ovf;
                st_d.exc = add_ovf && ove_i;
            end
            if (is_cmp) st_d.f = cmp_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cy_o        = st_q.cy;
    assign ov_o        = st_q.ov;
    assign f_o         = st_q.f;
    assign range_exc_o = st_q.exc;

    // R4: a pulse only follows an overflowing add with trapping enabled
    p_exc_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        range_exc_o |-> (ov_o && $past(ove_i) && $past(valid_i)))
        else $error("range exception without enabled overflow");

    // R7: compares leave carry and overflow alone
    p_cmp_only_f_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && is_cmp) |=> ($stable(cy_o) && $stable(ov_o)))
        else $error("compare disturbed CY or OV");

    // R11: idle cycles hold all flags and drop the pulse
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(cy_o) && $stable(ov_o) && $stable(f_o) && !range_exc_o))
        else $error("flags moved without valid");

    // R5: logic ops keep all flags
    p_logic_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_SUB))
        |=> ($stable(cy_o) && $stable(ov_o) && $stable(f_o)))
        else $error("logic op changed flags");

    // R8: conditional select follows the incoming flag
    p_cmov_pick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CMOV) |-> (f_i ? (result_o == a_i) : (result_o == b_i)))
        else $error("conditional move picked wrong operand");
endmodule

// File: tb/tb_int_alu.sv
module tb_int_alu;
    import alu_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [4:0]  op_i = '0;
    logic [31:0] a_i = '0, b_i = '0;
    logic        cy_i = 1'b0, f_i = 1'b0, ove_i = 1'b0;
    logic [31:0] result_o;
    logic        cy_o, ov_o, f_o, range_exc_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    int_alu dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .cy_i(cy_i), .f_i(f_i), .ove_i(ove_i),
        .result_o(result_o), .cy_o(cy_o), .ov_o(ov_o), .f_o(f_o),
        .range_exc_o(range_exc_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One operation: result checked before the edge, status after it
    task automatic run(input string req, input alu_op_e op,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic cin, input logic fin, input logic ove,
                       input logic [31:0] exp_res, input logic exp_cy,
                       input logic exp_ov, input logic exp_f, input logic exp_exc);
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; cy_i = cin; f_i = fin; ove_i = ove;
        valid_i = 1'b1;
        #1;
        check(req, "result", result_o, exp_res);
        @(negedge clk);
        valid_i = 1'b0;
        check(req, "cy", 32'(cy_o), 32'(exp_cy));
        check(req, "ov", 32'(ov_o), 32'(exp_ov));
        check(req, "f", 32'(f_o), 32'(exp_f));
        check(req, "exc", 32'(range_exc_o), 32'(exp_exc));
    endtask

    task automatic t_reset();
        check("R11", "reset cy", 32'(cy_o), 0);
        check("R11", "reset ov", 32'(ov_o), 0);
        check("R11", "reset f", 32'(f_o), 0);
        check("R11", "reset exc", 32'(range_exc_o), 0);
    endtask

    task automatic t_add();
        // R1 R2 R4: signed overflow with trap enabled
        run("R4", OP_ADD, 32'h7FFF_FFFF, 32'h1, 0, 0, 1, 32'h8000_0000, 0, 1, 0, 1);
        @(negedge clk);
        check("R4", "pulse drops", 32'(range_exc_o), 0);
        // R2: unsigned wrap, no signed overflow
        run("R2", OP_ADD, 32'hFFFF_FFFF, 32'h1, 0, 0, 1, 32'h0, 1, 0, 0, 0);
        // R1 R4: overflow and carry together, trap disabled
        run("R1", OP_ADD, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 32'h0, 1, 1, 0, 0);
        run("R1", OP_ADD, 32'd20, 32'd22, 0, 0, 1, 32'd42, 0, 0, 0, 0);
    endtask

    task automatic t_addc();
        run("R3", OP_ADDC, 32'h0, 32'hFFFF_FFFF, 1, 0, 0, 32'h0, 1, 0, 0, 0);
        run("R3", OP_ADDC, 32'd5, 32'd6, 1, 0, 0, 32'd12, 0, 0, 0, 0);
        run("R3", OP_ADDC, 32'h0, 32'hFFFF_FFFF, 0, 0, 0, 32'hFFFF_FFFF, 0, 0, 0, 0);
        run("R3", OP_ADDC, 32'h7FFF_FFFF, 32'h0, 1, 0, 1, 32'h8000_0000, 0, 1, 0, 1);
    endtask

    task automatic t_logic_keep();
        // leave CY=1 OV=1 then show logic/sub do not touch them
        run("R1", OP_ADD, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 32'h0, 1, 1, 0, 0);
        run("R5", OP_AND, 32'hF0F0_1234, 32'h0FF0_FF00, 0, 0, 1, 32'h00F0_1200, 1, 1, 0, 0);
        run("R5", OP_OR,  32'hF000_0001, 32'h0000_0F00, 0, 0, 1, 32'hF000_0F01, 1, 1, 0, 0);
        run("R5", OP_XOR, 32'hFFFF_0000, 32'h0F0F_0F0F, 0, 0, 1, 32'hF0F0_0F0F, 1, 1, 0, 0);
        run("R5", OP_SUB, 32'h0, 32'h1, 0, 0, 1, 32'hFFFF_FFFF, 1, 1, 0, 0);
    endtask

    task automatic t_shift();
        run("R6", OP_ROR, 32'h1234_5678, 32'd4,  0, 0, 0, 32'h8123_4567, 1, 1, 0, 0);
        run("R6", OP_ROR, 32'h1234_5678, 32'd32, 0, 0, 0, 32'h1234_5678, 1, 1, 0, 0);
        run("R6", OP_ROR, 32'h1234_5678, 32'd36, 0, 0, 0, 32'h8123_4567, 1, 1, 0, 0);
        run("R6", OP_SRA, 32'h8000_0000, 32'd31, 0, 0, 0, 32'hFFFF_FFFF, 1, 1, 0, 0);
        run("R6", OP_SRL, 32'h8000_0000, 32'd31, 0, 0, 0, 32'h1, 1, 1, 0, 0);
        run("R6", OP_SLL, 32'h1, 32'd33, 0, 0, 0, 32'h2, 1, 1, 0, 0);
    endtask

    task automatic t_compare();
        run("R7", OP_CMPGTS, 32'h1, 32'hFFFF_FFFF, 0, 0, 0, 0, 1, 1, 1, 0);
        run("R7", OP_CMPGTU, 32'h1, 32'hFFFF_FFFF, 0, 0, 0, 0, 1, 1, 0, 0);
        run("R7", OP_CMPEQ,  32'h55, 32'h55, 0, 0, 0, 0, 1, 1, 1, 0);
        run("R7", OP_CMPNE,  32'h55, 32'h55, 0, 0, 0, 0, 1, 1, 0, 0);
        run("R7", OP_CMPLES, 32'h8000_0000, 32'h0, 0, 0, 0, 0, 1, 1, 1, 0);
        run("R7", OP_CMPLEU, 32'h8000_0000, 32'h0, 0, 0, 0, 0, 1, 1, 0, 0);
        run("R7", OP_CMPGES, 32'h7, 32'h7, 0, 0, 0, 0, 1, 1, 1, 0);
        run("R7", OP_CMPLTS, 32'h7, 32'h7, 0, 0, 0, 0, 1, 1, 0, 0);
        run("R7", OP_CMPGEU, 32'h3, 32'h4, 0, 0, 0, 0, 1, 1, 0, 0);
        run("R7", OP_CMPLTU, 32'h3, 32'h4, 0, 0, 0, 0, 1, 1, 1, 0);
    endtask

    task automatic t_select_ext_scan();
        run("R8", OP_CMOV, 32'hAAAA_AAAA, 32'h5555_5555, 0, 1, 0, 32'hAAAA_AAAA, 1, 1, 1, 0);
        run("R8", OP_CMOV, 32'hAAAA_AAAA, 32'h5555_5555, 0, 0, 0, 32'h5555_5555, 1, 1, 1, 0);
        run("R10", OP_EXTBS, 32'h1234_56F0, 0, 0, 0, 0, 32'hFFFF_FFF0, 1, 1, 1, 0);
        run("R10", OP_EXTBZ, 32'h1234_56F0, 0, 0, 0, 0, 32'h0000_00F0, 1, 1, 1, 0);
        run("R10", OP_EXTHS, 32'h1234_8001, 0, 0, 0, 0, 32'hFFFF_8001, 1, 1, 1, 0);
        run("R10", OP_EXTHZ, 32'h1234_8001, 0, 0, 0, 0, 32'h0000_8001, 1, 1, 1, 0);
        run("R9", OP_FF1, 32'h0001_0100, 0, 0, 0, 0, 32'd9,  1, 1, 1, 0);
        run("R9", OP_FL1, 32'h0001_0100, 0, 0, 0, 0, 32'd17, 1, 1, 1, 0);
        run("R9", OP_FF1, 32'h0, 0, 0, 0, 0, 32'd0, 1, 1, 1, 0);
        run("R9", OP_FL1, 32'h0, 0, 0, 0, 0, 32'd0, 1, 1, 1, 0);
        run("R9", OP_FL1, 32'h8000_0000, 0, 0, 0, 0, 32'd32, 1, 1, 1, 0);
        run("R9", OP_FF1, 32'h8000_0001, 0, 0, 0, 0, 32'd1, 1, 1, 1, 0);
    endtask

    task automatic t_idle();
        // R11: an overflowing add with valid low must not touch flags
        @(negedge clk);
        op_i = OP_ADD; a_i = 32'h7FFF_FFFF; b_i = 32'h1; ove_i = 1'b1; valid_i = 1'b0;
        #1;
        check("R11", "comb result without valid", result_o, 32'h8000_0000);
        @(negedge clk);
        check("R11", "idle cy", 32'(cy_o), 1);
        check("R11", "idle ov", 32'(ov_o), 1);
        check("R11", "idle f", 32'(f_o), 1);
        check("R11", "idle exc", 32'(range_exc_o), 0);
        run("R2", OP_ADD, 32'h1, 32'h2, 0, 0, 1, 32'h3, 0, 0, 1, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add();
        t_addc();
        t_logic_keep();
        t_shift();
        t_compare();
        t_select_ext_scan();
        t_idle();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule